// File: doc/BRIEF.md
# Clocked serial link sniffer

The block listens, without driving anything, to a two-data-line serial link that has a clock but no select or framing line. A host produces the clock and one data line, a peripheral answers on a second data line, and after each byte the peripheral itself pulls the clock low for a while to acknowledge, or to signal that it is busy. The sniffer has to find byte boundaries on its own. It counts rising clock edges, and it treats a clock low that starts after a long quiet high period as the peripheral's acknowledge/busy pulse.

For every byte that completes normally, the sniffer issues one record on a valid/ready interface. The record holds the host byte, the peripheral byte and three durations counted in system-clock ticks: how long the transfer took, how long the peripheral waited before pulling the clock low, and how long it held the clock low. The link may run with long or short half periods, and the sniffer follows either one without being configured. One threshold, `GAP_TICKS`, separates the data half periods from the quiet time that comes before the acknowledge.

Top module: `snoop_link`

## Requirements
- R1: The three link inputs pass through a `SYNC_STAGES`-deep synchronizer. On each rising link-clock edge, both data lines are sampled. The bits are shifted in most significant bit first, and `BYTE_W` (8) samples make the host and peripheral bytes of a record.
- R2: `rec_xfer` equals the number of system ticks from the first falling link-clock edge of the byte to its eighth rising edge.
- R3: When the first falling edge after the eighth rising edge comes more than `GAP_TICKS` ticks after that rising edge, it is the acknowledge pulse, and `rec_ackd` equals that interval in ticks.
- R4: `rec_busy` equals the ticks from the acknowledge fall to the next rising edge. The record is issued on that rising edge.
- R5: Each duration saturates at 2^`CNT_W`-1 and never wraps.
- R6: A falling edge that comes no more than `GAP_TICKS` ticks after the eighth rising edge is taken as the first bit of a new byte. The unfinished byte gives no record.
- R7: A falling edge inside a byte (fewer than eight rising edges seen) that comes more than `GAP_TICKS` ticks after the last rising edge marks a broken byte. No record is issued, the low pulse is skipped, and the next falling edge starts a new byte.
- R8: Any half period from 2 up to `GAP_TICKS` ticks is decoded correctly, with no setting to change.
- R9: While `rec_valid` is high and `rec_ready` is low, every record field holds still. `rec_valid` falls only after a cycle in which `rec_ready` was high.
- R10: A record that completes while the output slot is still held is dropped. The next record delivered has `rec_lost` = 1, and records delivered otherwise have `rec_lost` = 0.
- R11: After reset, `rec_valid` and `rec_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnk_clk | input | 1 | Observed link clock, idle high |
| lnk_hd | input | 1 | Observed host data line |
| lnk_pd | input | 1 | Observed peripheral data line |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record available |
| rec_host | output | BYTE_W | Host byte |
| rec_peri | output | BYTE_W | Peripheral byte |
| rec_xfer | output | CNT_W | Transfer duration in ticks |
| rec_ackd | output | CNT_W | Delay before acknowledge in ticks |
| rec_busy | output | CNT_W | Acknowledge/busy low duration in ticks |
| rec_lost | output | 1 | One or more records dropped before this one |

## Verification
Bytes are sent with half periods of 3 and 30 ticks and also at exactly `GAP_TICKS`. Together these show whether data lows are separated from the acknowledge purely by the threshold. One acknowledge delay sits one tick above the threshold, and one busy pulse is longer than the counter can hold, so both the boundary and the saturation are exercised.

Two broken sequences test the resynchronisation rules. In one, a byte is followed quickly by another byte. In the other, a three-bit fragment is followed by a late low pulse. These show whether stale bits ever leak into a record. Holding `rec_ready` low across three bytes shows that the first record is kept, that the later two are dropped, and that the drop is flagged.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_WAIT,
      ST_BUSY,
      ST_SKIP
   } snoop_st_e;

endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] lvl
);

   logic [STAGES-1:0][N-1:0] stg;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg[0] <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg <= {stg[STAGES-2:0], din};
         end
      end
   endgenerate

   assign lvl = stg[STAGES-1];

endmodule

// File: rtl/snoop_sat_ctr.sv
module snoop_sat_ctr #(
   parameter int           W     = 24,
   parameter logic [W-1:0] LIMIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= W'(1);
      else if (cnt != LIMIT)   cnt <= cnt + W'(1);
   end

   // R5
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LIMIT && !restart) |=> cnt == LIMIT);

endmodule

// File: rtl/snoop_framer.sv
module snoop_framer
   import snoop_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 24,
   parameter int GAP_TICKS = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              hd,
   input  logic              pd,
   output logic              fire,
   output logic [BYTE_W-1:0] host_b,
   output logic [BYTE_W-1:0] peri_b,
   output logic [CNT_W-1:0]  xfer,
   output logic [CNT_W-1:0]  ackd,
   output logic [CNT_W-1:0]  busy
);

   localparam int               GAP_W   = $clog2(GAP_TICKS + 2);
   localparam int               BIT_W   = $clog2(BYTE_W + 1);
   localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_TICKS + 1);
   localparam logic [GAP_W-1:0] GAP_THR = GAP_W'(GAP_TICKS);
   localparam logic [BIT_W-1:0] LAST    = BIT_W'(BYTE_W - 1);

   snoop_st_e          st;
   logic [BIT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  sh_h, sh_p;
   logic [CNT_W-1:0]   xfer_q, ackd_q, tmr;
   logic [GAP_W-1:0]   gap_q;
   logic               tmr_rst, gap_over, last_bit;

   snoop_sat_ctr #(.W(CNT_W), .LIMIT({CNT_W{1'b1}})) u_tmr (
      .clk(clk), .rst_n(rst_n), .restart(tmr_rst), .cnt(tmr)
   );

   snoop_sat_ctr #(.W(GAP_W), .LIMIT(GAP_LIM)) u_gap (
      .clk(clk), .rst_n(rst_n), .restart(rise), .cnt(gap_q)
   );

   assign gap_over = gap_q > GAP_THR;
   assign last_bit = bit_cnt == LAST;

   always_comb begin
      tmr_rst = 1'b0;
      fire    = 1'b0;
      unique case (st)
         ST_IDLE:  tmr_rst = fall;
         ST_SHIFT: tmr_rst = rise && last_bit;
         ST_WAIT:  tmr_rst = fall;
         ST_BUSY:  fire    = rise;
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bit_cnt <= '0;
         sh_h    <= '0;
         sh_p    <= '0;
         xfer_q  <= '0;
         ackd_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (fall) begin
               st      <= ST_SHIFT;
               bit_cnt <= '0;
            end
            ST_SHIFT: begin
               if (rise) begin
                  sh_h    <= {sh_h[BYTE_W-2:0], hd};
                  sh_p    <= {sh_p[BYTE_W-2:0], pd};
                  bit_cnt <= bit_cnt + BIT_W'(1);
                  if (last_bit) begin
                     st     <= ST_WAIT;
                     xfer_q <= tmr;
                  end
               end else if (fall && gap_over) begin
                  st <= ST_SKIP;
               end
            end
            ST_WAIT: if (fall) begin
               if (gap_over) begin
                  st     <= ST_BUSY;
                  ackd_q <= tmr;
               end else begin
                  st      <= ST_SHIFT;
                  bit_cnt <= '0;
               end
            end
            ST_BUSY: if (rise) st <= ST_IDLE;
            ST_SKIP: if (rise) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign host_b = sh_h;
   assign peri_b = sh_p;
   assign xfer   = xfer_q;
   assign ackd   = ackd_q;
   assign busy   = tmr;

   // R1
   byte_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> bit_cnt == BIT_W'(BYTE_W));

endmodule

// File: rtl/snoop_link.sv
module snoop_link #(
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 24,
   parameter int GAP_TICKS   = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lnk_clk,
   input  logic              lnk_hd,
   input  logic              lnk_pd,
   input  logic              rec_ready,
   output logic              rec_valid,
   output logic [BYTE_W-1:0] rec_host,
   output logic [BYTE_W-1:0] rec_peri,
   output logic [CNT_W-1:0]  rec_xfer,
   output logic [CNT_W-1:0]  rec_ackd,
   output logic [CNT_W-1:0]  rec_busy,
   output logic              rec_lost
);

   initial begin : param_chk
      assert (BYTE_W >= 2)      else $error("BYTE_W must be at least 2");
      assert (CNT_W >= 4)       else $error("CNT_W must be at least 4");
      assert (GAP_TICKS >= 2)   else $error("GAP_TICKS must be at least 2");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic [2:0]        lvl;
   logic              clk_d, rise, fall, fire, load, drop, lost_pend;
   logic [BYTE_W-1:0] f_host, f_peri;
   logic [CNT_W-1:0]  f_xfer, f_ackd, f_busy;

   snoop_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({lnk_clk, lnk_hd, lnk_pd}), .lvl(lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_d <= 1'b1;
      else        clk_d <= lvl[2];
   end

   assign rise = lvl[2] & ~clk_d;
   assign fall = ~lvl[2] & clk_d;

   snoop_framer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .GAP_TICKS(GAP_TICKS)) u_frm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
      .hd(lvl[1]), .pd(lvl[0]), .fire(fire),
      .host_b(f_host), .peri_b(f_peri),
      .xfer(f_xfer), .ackd(f_ackd), .busy(f_busy)
   );

   assign load = fire && (!rec_valid || rec_ready);
   assign drop = fire && rec_valid && !rec_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid <= 1'b0;
         rec_lost  <= 1'b0;
         lost_pend <= 1'b0;
         rec_host  <= '0;
         rec_peri  <= '0;
         rec_xfer  <= '0;
         rec_ackd  <= '0;
         rec_busy  <= '0;
      end else begin
         if (load) begin
            rec_valid <= 1'b1;
            rec_lost  <= lost_pend;
            lost_pend <= 1'b0;
            rec_host  <= f_host;
            rec_peri  <= f_peri;
            rec_xfer  <= f_xfer;
            rec_ackd  <= f_ackd;
            rec_busy  <= f_busy;
         end else begin
            if (rec_valid && rec_ready) rec_valid <= 1'b0;
            if (drop)                   lost_pend <= 1'b1;
         end
      end
   end

   // R9
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_host) && $stable(rec_peri)
         && $stable(rec_xfer) && $stable(rec_ackd) && $stable(rec_busy) && $stable(rec_lost));

   // R9
   valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rec_valid) |-> $past(rec_ready));

   // R10
   drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> rec_valid);

   // R4
   fire_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (!rec_valid || rec_ready)) |=> rec_valid);

endmodule

// File: tb/snoop_link_bench.sv
module snoop_link_bench;

   localparam int CW   = 10;
   localparam int GAP  = 40;
   localparam int BW   = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lnk_clk = 1'b1, lnk_hd = 1'b1, lnk_pd = 1'b1, rec_ready = 1'b1;
   logic          rec_valid, rec_lost;
   logic [BW-1:0] rec_host, rec_peri;
   logic [CW-1:0] rec_xfer, rec_ackd, rec_busy;

   always #10 clk = ~clk;

   snoop_link #(.BYTE_W(BW), .CNT_W(CW), .GAP_TICKS(GAP), .SYNC_STAGES(2)) u_snoop_link (
      .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_hd(lnk_hd), .lnk_pd(lnk_pd),
      .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_host(rec_host), .rec_peri(rec_peri),
      .rec_xfer(rec_xfer), .rec_ackd(rec_ackd), .rec_busy(rec_busy), .rec_lost(rec_lost)
   );

   int compared = 0, mismatched = 0;
   bit done = 1'b0;
   int qh[$], qp[$], qx[$], qa[$], qb[$], ql[$];
   string qt[$];
   bit model_full = 1'b0, model_lost = 1'b0;

   function automatic int sat(int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural output-slot model: one held record, later ones dropped and flagged
   function automatic void push(int h, int p, int x, int a, int b, string tag);
      if (model_full) begin
         model_lost = 1'b1;
      end else begin
         qh.push_back(h); qp.push_back(p); qx.push_back(x);
         qa.push_back(a); qb.push_back(b); ql.push_back(int'(model_lost));
         qt.push_back(tag);
         model_lost = 1'b0;
         model_full = 1'b1;
      end
   endfunction

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(logic [7:0] h, logic [7:0] p, int half, int nbits);
      for (int i = 0; i < nbits; i++) begin
         lnk_clk = 1'b0;
         lnk_hd  = h[7-i];
         lnk_pd  = p[7-i];
         hold(half);
         lnk_clk = 1'b1;
         if (i != nbits - 1) hold(half);
      end
   endtask

   task automatic send_byte(logic [7:0] h, logic [7:0] p, int half, int ad, int bz, string tag);
      send_bits(h, p, half, 8);
      hold(ad);
      lnk_clk = 1'b0;
      hold(bz);
      lnk_clk = 1'b1;
      push(int'(h), int'(p), sat(15 * half), sat(ad), sat(bz), tag);
      hold(12);
   endtask

   // per-clock comparison, sampled between the falling and rising clock edges
   always begin
      @(negedge clk);
      #5;
      if (rst_n && !done) begin
         if (rec_valid && qh.size() == 0) begin
            check(1'b0, "R4", "unexpected record valid", 1, 0);
         end else if (rec_valid && rec_ready) begin
            check(int'(rec_host) == qh[0], "R1", {qt[0], " host byte"}, int'(rec_host), qh[0]);
            check(int'(rec_peri) == qp[0], "R1", {qt[0], " peripheral byte"}, int'(rec_peri), qp[0]);
            check(int'(rec_xfer) == qx[0], "R2", {qt[0], " transfer ticks"}, int'(rec_xfer), qx[0]);
            check(int'(rec_ackd) == qa[0], "R3", {qt[0], " ack delay ticks"}, int'(rec_ackd), qa[0]);
            check(int'(rec_busy) == qb[0], "R4", {qt[0], " busy ticks"}, int'(rec_busy), qb[0]);
            check(int'(rec_lost) == ql[0], "R10", {qt[0], " lost flag"}, int'(rec_lost), ql[0]);
            void'(qh.pop_front()); void'(qp.pop_front()); void'(qx.pop_front());
            void'(qa.pop_front()); void'(qb.pop_front()); void'(ql.pop_front());
            void'(qt.pop_front());
            model_full = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      hold(5);
      // R11 reset state
      check(rec_valid == 1'b0, "R11", "valid in reset", int'(rec_valid), 0);
      check(rec_lost == 1'b0, "R11", "lost in reset", int'(rec_lost), 0);
      rst_n = 1'b1;
      hold(5);
      check(rec_valid == 1'b0, "R11", "valid after reset", int'(rec_valid), 0);

      // R8 fast and slow half periods, plus half period equal to the threshold
      send_byte(8'hA5, 8'h3C, 3, 60, 8, "R8 fast");
      send_byte(8'h00, 8'hFF, 30, 50, 200, "R8 slow");
      send_byte(8'h5A, 8'hC3, GAP, 45, 5, "R8 boundary");
      // R3 ack delay one tick over the threshold
      send_byte(8'h81, 8'h7E, 3, GAP + 1, 6, "R3 edge");
      // R5 busy pulse longer than the counter range
      send_byte(8'h96, 8'h69, 30, 55, 1500, "R5 saturate");

      // R6 byte followed too soon by another byte: only the second is reported
      send_bits(8'h11, 8'h22, 3, 8);
      hold(5);
      send_byte(8'h33, 8'h44, 3, 60, 8, "R6 restart");

      // R7 three-bit fragment then a late low pulse: nothing reported
      hold(20);
      send_bits(8'hF0, 8'h0F, 3, 3);
      hold(60);
      lnk_clk = 1'b0;
      hold(20);
      lnk_clk = 1'b1;
      hold(30);
      check(rec_valid == 1'b0, "R7", "record after broken byte", int'(rec_valid), 0);
      check(qh.size() == 0, "R7", "pending expected records", qh.size(), 0);
      send_byte(8'h99, 8'h66, 3, 60, 8, "R7 recovery");

      // R9 / R10 stalled consumer
      hold(20);
      rec_ready = 1'b0;
      send_byte(8'hA1, 8'hB1, 3, 60, 8, "R9 held");
      send_byte(8'hA2, 8'hB2, 3, 60, 8, "R10 dropped");
      send_byte(8'hA3, 8'hB3, 3, 60, 8, "R10 dropped");
      hold(10);
      check(rec_valid == 1'b1, "R9", "valid while stalled", int'(rec_valid), 1);
      check(rec_host == 8'hA1, "R9", "held host byte", int'(rec_host), 'hA1);
      check(rec_lost == 1'b0, "R10", "held lost flag", int'(rec_lost), 0);
      rec_ready = 1'b1;
      hold(10);
      check(rec_valid == 1'b0, "R9", "valid after accept", int'(rec_valid), 0);
      send_byte(8'hA4, 8'hB4, 3, 60, 8, "R10 flagged");
      send_byte(8'hA5, 8'hB5, 3, 60, 8, "R10 clear");

      hold(20);
      check(qh.size() == 0, "R4", "records not delivered", qh.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule